// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block forms the 12-bit physical address into the data space of an 8-bit controller core. The data space is sixteen banks of 256 bytes each. An instruction names an operand by an 8-bit file field, and the unit turns that field into a full address in one of three ways.

In banked direct mode, the 4-bit bank register supplies the upper address bits. In access direct mode, the bank register plays no part: the low file values reach the bottom of the space, and the rest reach the top of the space. In indirect mode, one of three 12-bit pointers supplies the address. The pointer can stay unchanged, step before or after the access, or be offset by the signed working-register value.

The address output is combinational and follows its inputs within the same cycle. Pointer and bank-register writes, and automatic pointer steps, take effect at the next rising clock edge. An automatic step happens only on an edge where the access strobe is high.

Top module: `dmem_addr_gen`

## Requirements
- R1: With indirect mode off and the access bit at 1, the address is the bank register in bits 11:8 and the file field in bits 7:0.
- R2: With indirect mode off and the access bit at 0, a file value below 0x60 gives the address 0x000 plus the file value, whatever the bank register holds.
- R3: With indirect mode off and the access bit at 0, a file value of 0x60 or above gives 0xF00 plus the file value, whatever the bank register holds.
- R4: With indirect mode on and operation code 0 (plain), or any code from 5 to 7, the address is the selected pointer and the pointer keeps its value.
- R5: Operation code 1 (step up after) and code 2 (step down after) address the current pointer value. After the strobed edge, the pointer holds that value plus or minus one, modulo 4096.
- R6: Operation code 3 (step up before) addresses the pointer plus one, modulo 4096. After the strobed edge, the pointer holds that same value.
- R7: Operation code 4 (offset) addresses the pointer plus the working register read as a signed 8-bit value, modulo 4096. The pointer keeps its value.
- R8: No pointer changes on an edge where the access strobe is 0, unless it is loaded.
- R9: A pointer load takes effect at the next edge, with or without the strobe. It wins over an automatic step to the same pointer in that cycle, and does not block a step to a different pointer.
- R10: After reset, all three pointers and the bank register read zero. A bank register load takes effect at the next edge.
- R11: An automatic step changes only the selected pointer. A pointer index of 3 selects pointer 2, for both addressing and stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_en | input | 1 | Access strobe; allows automatic pointer steps at the edge |
| file_fld | input | 8 | File field of the operand |
| bank_sel | input | 1 | Access bit: 1 = use the bank register, 0 = use the split access window |
| ind_mode | input | 1 | 1 = address through a pointer |
| ind_op | input | 3 | Pointer operation code (0 plain, 1 step up after, 2 step down after, 3 step up before, 4 offset) |
| ptr_idx | input | 2 | Index of the pointer used in indirect mode |
| wreg | input | 8 | Working register value, a signed offset in mode 4 |
| bsr_wr | input | 1 | Load strobe for the bank register |
| bsr_wval | input | 4 | Bank register load value |
| ptr_wr | input | 1 | Load strobe for a pointer |
| ptr_wr_idx | input | 2 | Index of the pointer to load |
| ptr_wr_val | input | 12 | Pointer load value |
| phys_addr | output | 12 | Physical data address |
| bsr_q | output | 4 | Current bank register |
| ptr_q | output | 36 | All three pointers, pointer n in bits 12n+11:12n |

## Verification
A corrupted bank register or pointer reaches phys_addr in the same cycle it is used, and ptr_q shows it directly. Every pointer step is checked one edge after its strobe, so a bad step shows up within one cycle. A step that reaches the wrong pointer shows as a change in a pointer that should have held. The checks also cover wrap at 0x000 and 0xFFF, offsets of both signs, and a load colliding with a step on the same edge.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_POSTINC = 3'd1,
    OP_POSTDEC = 3'd2,
    OP_PREINC  = 3'd3,
    OP_OFFSET  = 3'd4
  } ind_op_e;
endpackage

// File: rtl/dmau_direct.sv
module dmau_direct #(
  parameter int FILE_W  = 8,
  parameter int BANK_W  = 4,
  parameter int ACC_LOW = 96
) (
  input  logic [FILE_W-1:0]        file_fld,
  input  logic                     banked,
  input  logic [BANK_W-1:0]        bsr,
  output logic [FILE_W+BANK_W-1:0] addr
);
  localparam logic [FILE_W-1:0] SPLIT  = FILE_W'(ACC_LOW);
  localparam logic [BANK_W-1:0] TOP_BK = {BANK_W{1'b1}};

  always_comb begin
    if (banked) begin
      addr = {bsr, file_fld};
    end else if (file_fld < SPLIT) begin
      addr = {{BANK_W{1'b0}}, file_fld};
    end else begin
      addr = {TOP_BK, file_fld};
    end
  end
endmodule

// File: rtl/dmau_ind_calc.sv
module dmau_ind_calc
  import dmau_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    op,
  input  logic [DW-1:0] off,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt,
  output logic          upd
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] off_x;
  logic [AW-1:0] plus1;
  logic [AW-1:0] minus1;

  assign off_x  = {{EXT{off[DW-1]}}, off};
  assign plus1  = cur + AW'(1);
  assign minus1 = cur - AW'(1);

  always_comb begin
    addr = cur;
    nxt  = cur;
    upd  = 1'b0;
    case (op)
      OP_POSTINC: begin nxt = plus1;  upd = 1'b1; end
      OP_POSTDEC: begin nxt = minus1; upd = 1'b1; end
      OP_PREINC:  begin addr = plus1; nxt = plus1; upd = 1'b1; end
      OP_OFFSET:  addr = cur + off_x;
      default:    addr = cur;
    endcase
  end
endmodule

// File: rtl/dmau_ptr_file.sv
module dmau_ptr_file #(
  parameter int NPTR  = 3,
  parameter int AW    = 12,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPTR-1:0]    upd_sel,
  input  logic [AW-1:0]      upd_val,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [AW-1:0]      wr_val,
  output logic [NPTR*AW-1:0] ptr_q
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] q;
    logic [AW-1:0] d;
    logic          en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        d  = wr_val;
        en = 1'b1;
      end else if (upd_sel[g]) begin
        d  = upd_val;
        en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign ptr_q[g*AW +: AW] = q;
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmau_pkg::*;
#(
  parameter int FILE_W  = 8,
  parameter int BANK_W  = 4,
  parameter int NPTR    = 3,
  parameter int ACC_LOW = 96,
  localparam int ADDR_W = FILE_W + BANK_W,
  localparam int IDX_W  = $clog2(NPTR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic [FILE_W-1:0]      file_fld,
  input  logic                   bank_sel,
  input  logic                   ind_mode,
  input  logic [2:0]             ind_op,
  input  logic [IDX_W-1:0]       ptr_idx,
  input  logic [FILE_W-1:0]      wreg,
  input  logic                   bsr_wr,
  input  logic [BANK_W-1:0]      bsr_wval,
  input  logic                   ptr_wr,
  input  logic [IDX_W-1:0]       ptr_wr_idx,
  input  logic [ADDR_W-1:0]      ptr_wr_val,
  output logic [ADDR_W-1:0]      phys_addr,
  output logic [BANK_W-1:0]      bsr_q,
  output logic [NPTR*ADDR_W-1:0] ptr_q
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NPTR - 1);

  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic [BANK_W-1:0] bsr_d;
  logic              bsr_en;
  logic [IDX_W-1:0]  idx_c;
  logic [ADDR_W-1:0] cur_ptr;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] ind_addr;
  logic [ADDR_W-1:0] ind_nxt;
  logic              ind_upd;
  logic [NPTR-1:0]   upd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[1];

  always_comb begin
    bsr_en = bsr_wr;
    bsr_d  = bsr_wval;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      bsr_q <= '0;
    end else if (bsr_en) begin
      bsr_q <= bsr_d;
    end
  end

  assign idx_c   = (ptr_idx > IDX_MAX) ? IDX_MAX : ptr_idx;
  assign cur_ptr = ptr_q[int'(idx_c)*ADDR_W +: ADDR_W];

  dmau_direct #(
    .FILE_W (FILE_W),
    .BANK_W (BANK_W),
    .ACC_LOW(ACC_LOW)
  ) i_direct (
    .file_fld(file_fld),
    .banked  (bank_sel),
    .bsr     (bsr_q),
    .addr    (dir_addr)
  );

  dmau_ind_calc #(
    .AW(ADDR_W),
    .DW(FILE_W)
  ) i_ind (
    .cur (cur_ptr),
    .op  (ind_op),
    .off (wreg),
    .addr(ind_addr),
    .nxt (ind_nxt),
    .upd (ind_upd)
  );

  always_comb begin
    for (int g = 0; g < NPTR; g++) begin
      upd_sel[g] = acc_en && ind_mode && ind_upd && (idx_c == IDX_W'(g));
    end
  end

  dmau_ptr_file #(
    .NPTR (NPTR),
    .AW   (ADDR_W),
    .IDX_W(IDX_W)
  ) i_ptrs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .upd_sel(upd_sel),
    .upd_val(ind_nxt),
    .wr_en  (ptr_wr),
    .wr_idx (ptr_wr_idx),
    .wr_val (ptr_wr_val),
    .ptr_q  (ptr_q)
  );

  assign phys_addr = ind_mode ? ind_addr : dir_addr;
endmodule

// File: rtl/dmau_chk.sv
module dmau_chk #(
  parameter int FILE_W  = 8,
  parameter int BANK_W  = 4,
  parameter int NPTR    = 3,
  parameter int ACC_LOW = 96,
  localparam int ADDR_W = FILE_W + BANK_W,
  localparam int IDX_W  = $clog2(NPTR)
) (
  input logic                   clk,
  input logic                   rst_n_sync,
  input logic                   acc_en,
  input logic [FILE_W-1:0]      file_fld,
  input logic                   bank_sel,
  input logic                   ind_mode,
  input logic [2:0]             ind_op,
  input logic [IDX_W-1:0]       ptr_idx,
  input logic                   ptr_wr,
  input logic [IDX_W-1:0]       ptr_wr_idx,
  input logic [ADDR_W-1:0]      ptr_wr_val,
  input logic [ADDR_W-1:0]      phys_addr,
  input logic [BANK_W-1:0]      bsr_q,
  input logic [NPTR*ADDR_W-1:0] ptr_q
);
  function automatic logic [ADDR_W-1:0] pick(input logic [NPTR*ADDR_W-1:0] v,
                                             input logic [IDX_W-1:0] i);
    int k;
    k = (int'(i) > NPTR - 1) ? NPTR - 1 : int'(i);
    return v[k*ADDR_W +: ADDR_W];
  endfunction

  logic same_load;
  assign same_load = ptr_wr &&
    ((int'(ptr_wr_idx) > NPTR - 1 ? NPTR - 1 : int'(ptr_wr_idx)) ==
     (int'(ptr_idx) > NPTR - 1 ? NPTR - 1 : int'(ptr_idx))) &&
    (int'(ptr_wr_idx) < NPTR);

  p_banked_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ind_mode && bank_sel) |-> phys_addr == {bsr_q, file_fld});

  p_acc_low_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ind_mode && !bank_sel && file_fld < FILE_W'(ACC_LOW))
      |-> phys_addr[ADDR_W-1:FILE_W] == '0);

  p_acc_high_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!ind_mode && !bank_sel && file_fld >= FILE_W'(ACC_LOW))
      |-> phys_addr[ADDR_W-1:FILE_W] == {BANK_W{1'b1}});

  p_postinc_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (acc_en && ind_mode && ind_op == 3'd1 && !same_load)
      |=> pick(ptr_q, $past(ptr_idx)) == ADDR_W'(pick($past(ptr_q), $past(ptr_idx)) + 1'b1));

  p_preinc_addr_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ind_mode && ind_op == 3'd3)
      |-> phys_addr == ADDR_W'(pick(ptr_q, ptr_idx) + 1'b1));

  p_offset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ind_mode && ind_op == 3'd4 && !ptr_wr) |=> $stable(ptr_q));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!acc_en && !ptr_wr) |=> $stable(ptr_q));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ptr_wr && int'(ptr_wr_idx) < NPTR)
      |=> pick(ptr_q, $past(ptr_wr_idx)) == $past(ptr_wr_val));
endmodule

bind dmem_addr_gen dmau_chk #(
  .FILE_W (FILE_W),
  .BANK_W (BANK_W),
  .NPTR   (NPTR),
  .ACC_LOW(ACC_LOW)
) i_chk (
  .clk       (clk),
  .rst_n_sync(rst_n_sync),
  .acc_en    (acc_en),
  .file_fld  (file_fld),
  .bank_sel  (bank_sel),
  .ind_mode  (ind_mode),
  .ind_op    (ind_op),
  .ptr_idx   (ptr_idx),
  .ptr_wr    (ptr_wr),
  .ptr_wr_idx(ptr_wr_idx),
  .ptr_wr_val(ptr_wr_val),
  .phys_addr (phys_addr),
  .bsr_q     (bsr_q),
  .ptr_q     (ptr_q)
);

// File: tb/test_dmem_addr_gen.sv
`timescale 1ns/100ps
module test_dmem_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en;
  logic [7:0]  file_fld;
  logic        bank_sel;
  logic        ind_mode;
  logic [2:0]  ind_op;
  logic [1:0]  ptr_idx;
  logic [7:0]  wreg;
  logic        bsr_wr;
  logic [3:0]  bsr_wval;
  logic        ptr_wr;
  logic [1:0]  ptr_wr_idx;
  logic [11:0] ptr_wr_val;
  logic [11:0] phys_addr;
  logic [3:0]  bsr_q;
  logic [35:0] ptr_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [11:0] mp [3];

  always #2.5 clk = ~clk;

  dmem_addr_gen i_dmem_addr_gen (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .file_fld(file_fld),
    .bank_sel(bank_sel), .ind_mode(ind_mode), .ind_op(ind_op),
    .ptr_idx(ptr_idx), .wreg(wreg), .bsr_wr(bsr_wr), .bsr_wval(bsr_wval),
    .ptr_wr(ptr_wr), .ptr_wr_idx(ptr_wr_idx), .ptr_wr_val(ptr_wr_val),
    .phys_addr(phys_addr), .bsr_q(bsr_q), .ptr_q(ptr_q)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %03h expected %03h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] dir_exp(input logic bs, input logic [7:0] f, input logic [3:0] b);
    if (bs) return {b, f};
    if (f < 8'd96) return {4'h0, f};
    return {4'hF, f};
  endfunction

  task automatic chk_ptrs(input string tag);
    for (int k = 0; k < 3; k++) chk(tag, ptr_q[k*12 +: 12], mp[k]);
  endtask

  task automatic load_ptr(input int i, input logic [11:0] v);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wr_idx = 2'(i); ptr_wr_val = v;
    @(negedge clk);
    ptr_wr = 1'b0;
    mp[i] = v;
  endtask

  task automatic load_bsr(input logic [3:0] v);
    @(negedge clk);
    bsr_wr = 1'b1; bsr_wval = v;
    @(negedge clk);
    bsr_wr = 1'b0;
  endtask

  task automatic run_ind(input int i, input logic [2:0] op, input logic [7:0] w, input string tag);
    logic [11:0] s, ea, np;
    s  = mp[i];
    ea = s; np = s;
    case (op)
      3'd1: np = s + 12'd1;
      3'd2: np = s - 12'd1;
      3'd3: begin ea = s + 12'd1; np = ea; end
      3'd4: ea = s + {{4{w[7]}}, w};
      default: ;
    endcase
    @(negedge clk);
    ind_mode = 1'b1; ind_op = op; ptr_idx = 2'(i); wreg = w; acc_en = 1'b1;
    #1 chk(tag, phys_addr, ea);
    @(negedge clk);
    acc_en = 1'b0; ind_mode = 1'b0;
    mp[i] = np;
    #1 chk_ptrs(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] starts [6];
    logic [7:0]  offs [5];
    logic [3:0]  bsrs [4];
    starts = '{12'h000, 12'h001, 12'h7FF, 12'hFFE, 12'hFFF, 12'h5A5};
    offs   = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    bsrs   = '{4'h0, 4'h5, 4'hA, 4'hF};
    rst_n = 1'b0; acc_en = 1'b0; file_fld = '0; bank_sel = 1'b0; ind_mode = 1'b0;
    ind_op = '0; ptr_idx = '0; wreg = '0; bsr_wr = 1'b0; bsr_wval = '0;
    ptr_wr = 1'b0; ptr_wr_idx = '0; ptr_wr_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) mp[k] = '0;
    // R10 reset state
    chk("R10 bsr reset", 12'(bsr_q), 12'h000);
    chk_ptrs("R10 pointer reset");

    // R1 R2 R3 direct sweep
    for (int b = 0; b < 4; b++) begin
      load_bsr(bsrs[b]);
      chk("R10 bsr load", 12'(bsr_q), 12'(bsrs[b]));
      for (int a = 0; a < 2; a++) begin
        for (int f = 0; f < 256; f++) begin
          @(negedge clk);
          bank_sel = a[0]; file_fld = 8'(f);
          #1;
          if (a == 1) chk("R1 banked", phys_addr, dir_exp(1'b1, 8'(f), bsrs[b]));
          else if (f < 96) chk("R2 access low", phys_addr, dir_exp(1'b0, 8'(f), bsrs[b]));
          else chk("R3 access high", phys_addr, dir_exp(1'b0, 8'(f), bsrs[b]));
        end
      end
    end

    // R4 R5 R6 R7 R11 indirect sweep
    for (int i = 0; i < 3; i++) begin
      for (int s = 0; s < 6; s++) begin
        for (int op = 0; op < 8; op++) begin
          if (op == 4) begin
            for (int w = 0; w < 5; w++) begin
              load_ptr(i, starts[s]);
              load_ptr((i + 1) % 3, 12'h3C0 + 12'(i));
              load_ptr((i + 2) % 3, 12'hA11 + 12'(s));
              run_ind(i, 3'd4, offs[w], "R7 offset");
            end
          end else begin
            load_ptr(i, starts[s]);
            load_ptr((i + 1) % 3, 12'h3C0 + 12'(op));
            load_ptr((i + 2) % 3, 12'hA11 + 12'(s));
            if (op == 1 || op == 2) run_ind(i, 3'(op), 8'h33, "R5 R11 post step");
            else if (op == 3) run_ind(i, 3'(op), 8'h33, "R6 R11 pre step");
            else run_ind(i, 3'(op), 8'h33, "R4 plain");
          end
        end
      end
    end

    // R8 no strobe, no step
    load_ptr(0, 12'h100);
    @(negedge clk);
    ind_mode = 1'b1; ind_op = 3'd1; ptr_idx = 2'd0; acc_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ind_mode = 1'b0;
    #1 chk_ptrs("R8 strobe low");

    // R9 load beats step on same pointer
    load_ptr(1, 12'h200);
    @(negedge clk);
    ind_mode = 1'b1; ind_op = 3'd1; ptr_idx = 2'd1; acc_en = 1'b1;
    ptr_wr = 1'b1; ptr_wr_idx = 2'd1; ptr_wr_val = 12'h123;
    @(negedge clk);
    acc_en = 1'b0; ind_mode = 1'b0; ptr_wr = 1'b0;
    mp[1] = 12'h123;
    #1 chk_ptrs("R9 load wins");

    // R9 load on other pointer while stepping
    load_ptr(2, 12'hFFF);
    @(negedge clk);
    ind_mode = 1'b1; ind_op = 3'd1; ptr_idx = 2'd2; acc_en = 1'b1;
    ptr_wr = 1'b1; ptr_wr_idx = 2'd0; ptr_wr_val = 12'h456;
    @(negedge clk);
    acc_en = 1'b0; ind_mode = 1'b0; ptr_wr = 1'b0;
    mp[0] = 12'h456; mp[2] = 12'h000;
    #1 chk_ptrs("R9 load other pointer");

    // R11 index 3 selects pointer 2
    load_ptr(2, 12'h0AB);
    @(negedge clk);
    ind_mode = 1'b1; ind_op = 3'd2; ptr_idx = 2'd3; acc_en = 1'b1;
    #1 chk("R11 index 3 address", phys_addr, 12'h0AB);
    @(negedge clk);
    acc_en = 1'b0; ind_mode = 1'b0;
    mp[2] = 12'h0AA;
    #1 chk_ptrs("R11 index 3 step");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule